// File: doc/BRIEF.md
# Clear-Code Watchdog Timer

This block supervises software on a small controller. A free-running divider feeds a two-stage binary counter. When that counter overflows, the block either requests a system reset or raises a watchdog interrupt. The watchdog is live from reset and needs no software action to start. Software must write a fixed clear byte to a dedicated register often enough to prevent overflow. The byte restarts the binary stages but leaves the divider phase untouched, so the time from a clear to the next overflow is always between three quarters of the selected period and the full period.

Software programs the block through a byte write port with three addresses. Address 0 is the control register. Address 1 is the clear register. A write of any data to address 2 acknowledges a pending interrupt. A low-power input freezes the whole timing chain during stop or idle modes. When that input drops, counting resumes from the held value.

Top module: `wdt_clearcode`

## Requirements
- R1: Reset leaves both outputs low and sets the control register to period code 0 with reset mode selected. Counting starts without any write, and the first reset request is seen in the cycle after rising edge number 2^P after reset release, where P is `PERIOD_LOG2_MAX`.
- R2: Control bits [1:0] hold a period code c. Code c gives a divider tick every 2^(P-2-2c) running clocks and an overflow period of 2^(P-2c) clocks. With the default P=25 the codes 0..3 give 2^25, 2^23, 2^21 and 2^19 clocks.
- R3: Control bit 2 selects the overflow action. With 1, an overflow drives `wdt_rst_req`. With 0, an overflow sets `wdt_irq_req`. An overflow never drives the other output.
- R4: `wdt_rst_req` is high for exactly one clock per overflow: the cycle after the edge that carries the fourth tick.
- R5: `wdt_irq_req` stays high after it is set. Only a write of the clear byte 0x4E to address 1, or any write to address 2, takes it low, in the cycle after that write edge.
- R6: Writing 0x4E to address 1 zeroes the binary stages and leaves the divider alone. The next overflow follows the write edge by at least 3*T+1 and at most 4*T edges, where T is the tick spacing. A clear on an edge that also carries a tick wins over that tick.
- R7: A write of any other byte to address 1 changes neither the binary stages nor `wdt_irq_req`.
- R8: While `lp_hold` is high, neither the divider nor the stages advance and no overflow occurs. After release, counting continues from the held values.
- R9: The stages wrap to zero on overflow, so overflows recur every period without software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_hold | input | 1 | High during stop or idle mode, including warm-up; freezes counting |
| reg_we | input | 1 | Register write strobe, one write per high cycle |
| reg_addr | input | 2 | 0 control, 1 clear, 2 interrupt acknowledge |
| reg_wdata | input | 8 | Write data |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| wdt_irq_req | output | 1 | Held watchdog interrupt request |

## Verification
The assertions assume that `reg_we` is sampled on every edge and that `lp_hold` is a clean synchronous level. They also assume that no write reaches address 1 or address 2 in the same cycle in which the checker expects an interrupt to stay set. The stimulus changes every input only at falling clock edges. It places each register write at a known rising-edge index, so each write lands either on a tick edge or between ticks, as the case requires. The low-power window covers a tick that would otherwise fire. Every clear of a pending interrupt is issued only while that interrupt is known to be high.

// File: rtl/wdt_cc_pkg.sv
package wdt_cc_pkg;
   localparam int STAGE_W  = 2;
   localparam int SEL_W    = 2;
   localparam int SEL_STEP = 2;
   localparam int NUM_SEL  = 2 ** SEL_W;

   typedef enum logic [1:0] {
      WDA_CTRL  = 2'd0,
      WDA_CLEAR = 2'd1,
      WDA_ACK   = 2'd2,
      WDA_SPARE = 2'd3
   } wd_addr_e;

   typedef struct packed {
      logic             rst_mode;
      logic [SEL_W-1:0] tsel;
   } wd_ctrl_t;

   localparam wd_ctrl_t CTRL_RESET = '{rst_mode: 1'b1, tsel: '0};
endpackage

// File: rtl/wdt_cc_regs.sv
module wdt_cc_regs
   import wdt_cc_pkg::*;
#(
   parameter logic [7:0] CLEAR_CODE = 8'h4E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output wd_ctrl_t   ctrl,
   output logic       clr_hit,
   output logic       ack_hit
);
   wd_ctrl_t ctrl_q;
   logic     ctrl_wr;

   assign ctrl_wr = reg_we && (reg_addr == WDA_CTRL);
   assign clr_hit = reg_we && (reg_addr == WDA_CLEAR) && (reg_wdata == CLEAR_CODE);
   assign ack_hit = reg_we && (reg_addr == WDA_ACK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (ctrl_wr) begin
         ctrl_q.tsel     <= reg_wdata[SEL_W-1:0];
         ctrl_q.rst_mode <= reg_wdata[SEL_W];
      end
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/wdt_cc_prescaler.sv
module wdt_cc_prescaler
   import wdt_cc_pkg::*;
#(
   parameter int DIV_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] tsel,
   output logic             tick
);
   logic [DIV_W-1:0]   div_q;
   logic [NUM_SEL-1:0] code_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (run) div_q <= div_q + 1'b1;
   end

   for (genvar c = 0; c < NUM_SEL; c++) begin : g_tap
      localparam int K = DIV_W - SEL_STEP * c;
      assign code_tick[c] = &div_q[K-1:0];
   end

   assign tick = run && code_tick[tsel];
endmodule

// File: rtl/wdt_cc_stages.sv
module wdt_cc_stages #(
   parameter int STAGE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               clear,
   output logic               ovf,
   output logic [STAGE_W-1:0] cnt
);
   logic [STAGE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end

   assign ovf = tick && !clear && (&cnt_q);
   assign cnt = cnt_q;
endmodule

// File: rtl/wdt_clearcode.sv
module wdt_clearcode
   import wdt_cc_pkg::*;
#(
   parameter int         PERIOD_LOG2_MAX = 25,
   parameter logic [7:0] CLEAR_CODE      = 8'h4E
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lp_hold,
   input  logic       reg_we,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic       wdt_rst_req,
   output logic       wdt_irq_req
);
   localparam int DIV_W = PERIOD_LOG2_MAX - STAGE_W;

   if (DIV_W - SEL_STEP * (NUM_SEL - 1) < 1) begin : g_bad_period
      $error("PERIOD_LOG2_MAX too small for the shortest period code");
   end
   if (PERIOD_LOG2_MAX > 40) begin : g_bad_width
      $error("PERIOD_LOG2_MAX too large");
   end

   wd_ctrl_t           ctrl_q;
   logic               clr_hit, ack_hit, tick, ovf, run;
   logic               mode_rst;
   logic [STAGE_W-1:0] stage_cnt;
   logic               rst_q, irq_q;

   assign run      = !lp_hold;
   assign mode_rst = ctrl_q.rst_mode;

   wdt_cc_regs #(.CLEAR_CODE(CLEAR_CODE)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ctrl(ctrl_q), .clr_hit(clr_hit), .ack_hit(ack_hit)
   );

   wdt_cc_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .tsel(ctrl_q.tsel), .tick(tick)
   );

   wdt_cc_stages #(.STAGE_W(STAGE_W)) u_stg (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clr_hit),
      .ovf(ovf), .cnt(stage_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         rst_q <= ovf && mode_rst;
         if (ovf && !mode_rst)        irq_q <= 1'b1;
         else if (clr_hit || ack_hit) irq_q <= 1'b0;
      end
   end

   assign wdt_rst_req = rst_q;
   assign wdt_irq_req = irq_q;
endmodule

// File: rtl/wdt_clearcode_chk.sv
module wdt_clearcode_chk #(
   parameter logic [7:0] CLEAR_CODE = 8'h4E,
   parameter int         STAGE_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lp_hold,
   input logic               reg_we,
   input logic [1:0]         reg_addr,
   input logic [7:0]         reg_wdata,
   input logic               rst_req,
   input logic               irq_req,
   input logic               rst_mode,
   input logic [STAGE_W-1:0] stage_cnt
);
   logic good_wr, bad_wr;
   assign good_wr = reg_we && (reg_addr == 2'd1) && (reg_wdata == CLEAR_CODE);
   assign bad_wr  = reg_we && (reg_addr == 2'd1) && (reg_wdata != CLEAR_CODE);

   AST_RST_ONLY_IN_RST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(rst_mode)); // R3
   AST_IRQ_ONLY_IN_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> !$past(rst_mode)); // R3
   AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R4
   AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> !irq_req); // R5
   AST_CLEAR_ZEROES_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
      good_wr |=> (stage_cnt == '0)); // R6
   AST_BAD_CODE_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_wr && irq_req) |=> irq_req); // R7
   AST_NO_OVERFLOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lp_hold |=> (!rst_req && !$rose(irq_req))); // R8
   AST_STAGES_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_hold && !good_wr) |=> $stable(stage_cnt)); // R8
endmodule

bind wdt_clearcode wdt_clearcode_chk #(.CLEAR_CODE(CLEAR_CODE), .STAGE_W(wdt_cc_pkg::STAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rst_req(wdt_rst_req),
   .irq_req(wdt_irq_req), .rst_mode(mode_rst), .stage_cnt(stage_cnt)
);

// File: tb/wdt_clearcode_tb.sv
`timescale 1ns/1ps
module wdt_clearcode_tb;
   localparam int P = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lp_hold = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       wdt_rst_req, wdt_irq_req;
   int         cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   wdt_clearcode #(.PERIOD_LOG2_MAX(P)) u_dut (
      .clk(clk), .rst_n(rst_n), .lp_hold(lp_hold), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .wdt_rst_req(wdt_rst_req), .wdt_irq_req(wdt_irq_req)
   );

   typedef struct { int at; int kind; string tag; } exp_t;
   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   prev_irq = 1'b0;

   function automatic string kname(int k);
      return (k == 0) ? "RST" : (k == 1) ? "IRQ_SET" : "IRQ_CLR";
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic expect_ev(int at, int kind, string tag);
      exp_t e;
      e.at = at; e.kind = kind; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic observe(int kind);
      exp_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R3", {"unexpected ", kname(kind), " at cycle"}, cyc, -1);
      end else begin
         e = q.pop_front();
         chk(e.kind == kind, e.tag, "event kind", kind, e.kind);
         chk(e.at == cyc, e.tag, {kname(kind), " cycle"}, cyc, e.at);
      end
   endtask

   task automatic monitor();
      forever begin
         @(negedge clk);
         if (rst_n) begin
            while (q.size() > 0 && q[0].at < cyc) begin
               chk(1'b0, q[0].tag, {"missed ", kname(q[0].kind), " at cycle"}, cyc, q[0].at);
               void'(q.pop_front());
            end
            if (wdt_rst_req) observe(0);
            if (wdt_irq_req && !prev_irq) observe(1);
            if (!wdt_irq_req && prev_irq) observe(2);
            prev_irq = wdt_irq_req;
         end
      end
   endtask

   task automatic wr(int at, logic [1:0] a, logic [7:0] d);
      do @(negedge clk); while (cyc != at - 1);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic freeze(int first, int last);
      do @(negedge clk); while (cyc != first - 1);
      lp_hold = 1'b1;
      do @(negedge clk); while (cyc != last);
      lp_hold = 1'b0;
   endtask

   task automatic run_seq();
      // R1: reset mode, code 0 -> period 2^P = 512
      expect_ev(512, 0, "R1");
      // R2/R3: code 3 (tick 2, period 8) in interrupt mode
      wr(540, 2'd0, 8'h03);
      expect_ev(548, 1, "R2");
      wr(560, 2'd2, 8'h00);
      expect_ev(560, 2, "R5");
      expect_ev(564, 1, "R9");
      // R6: clear on a tick edge wins, full period follows
      wr(566, 2'd1, 8'h4E);
      expect_ev(566, 2, "R5");
      expect_ev(574, 1, "R6");
      // code 2: tick 8, period 32
      wr(577, 2'd0, 8'h02);
      // R6: clear just before a tick -> shortest case 25 edges
      wr(583, 2'd1, 8'h4E);
      expect_ev(583, 2, "R5");
      expect_ev(608, 1, "R6");
      // R6: clear on a tick edge -> longest case 32 edges
      wr(616, 2'd1, 8'h4E);
      expect_ev(616, 2, "R5");
      expect_ev(648, 1, "R6");
      // R8: 10 frozen edges shift the later ticks by 10
      freeze(650, 659);
      wr(662, 2'd2, 8'h55);
      expect_ev(662, 2, "R5");
      expect_ev(690, 1, "R8");
      // R3: switch to reset mode, code 2
      wr(692, 2'd0, 8'h06);
      wr(694, 2'd2, 8'h00);
      expect_ev(694, 2, "R5");
      expect_ev(722, 0, "R3");
      // R7: wrong byte after one tick must not restart the stages
      wr(733, 2'd1, 8'h4F);
      expect_ev(754, 0, "R7");
      // R6: good clear between ticks
      wr(757, 2'd1, 8'h4E);
      expect_ev(786, 0, "R6");
      do @(negedge clk); while (cyc < 800);
   endtask

   initial begin
      bit timed_out = 1'b0;
      repeat (3) @(negedge clk);
      chk(wdt_rst_req == 1'b0, "R1", "rst_req in reset", wdt_rst_req, 0);
      chk(wdt_irq_req == 1'b0, "R1", "irq_req in reset", wdt_irq_req, 0);
      rst_n = 1'b1;
      fork
         monitor();
      join_none
      fork
         run_seq();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) chk(1'b0, "R1", "watchdog expired at cycle", cyc, 0);
      chk(q.size() == 0, "R9", "events left pending", q.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule